// File: doc/BRIEF.md
# Timer Interrupt Status and Enable Unit

This block keeps the pending-event status and the per-source enables for one 8-bit timer/counter. The timer has three interrupt sources: an overflow and two compare channels, A and B. The counter core sends this block a one-cycle pulse for each event. Each pulse sets a sticky status bit. The overflow pulse is recorded only when a qualifying input from the counter's mode decoder is high.

Software reaches two byte-wide registers over a simple register bus that has separate write and read paths. The status register holds the three pending bits. The enable register holds the three source enables. Software clears a pending bit by writing a one to it. The interrupt controller also clears a pending bit by pulsing that source's acknowledge when it takes the vector.

The block drives one request line per source. A request line is high only while the global interrupt enable, the source enable and the pending bit are all set. There is no streaming data path: every pin is plain control or status. A read returns data in the same cycle, and a write takes effect at the next clock edge.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, the status register and the enable register both read 0x00 and all request lines are low.
- R2: A pulse on `evt_cmp_b`, `evt_cmp_a` or `evt_ovf` sets status bit 2, bit 1 or bit 0 respectively at the next clock edge. The bit stays set until it is cleared.
- R3: An overflow pulse while `ovf_mode_ok` is low leaves status bit 0 unchanged.
- R4: A write to the status register (`reg_wr_sel`=0) clears each status bit whose data bit is one. Status bits whose data bit is zero are left unchanged.
- R5: A pulse on `irq_ack[i]` clears status bit i at the next edge. Index 0 is overflow, 1 is compare A and 2 is compare B.
- R6: When a setting event and a clear (by write or by acknowledge) reach the same status bit in the same cycle, the bit ends up set.
- R7: `irq_req[i]` is high exactly when `gie`, enable bit i and status bit i are all one.
- R8: Bits 7 to 3 of both registers always read as zero, and writes to those bits have no effect.
- R9: A write to the enable register (`reg_wr_sel`=1) loads bits 2 to 0 from the data. If a status bit is already pending when its enable is written to one, its request rises from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_ovf | input | 1 | Counter overflow pulse |
| evt_cmp_a | input | 1 | Compare channel A match pulse |
| evt_cmp_b | input | 1 | Compare channel B match pulse |
| ovf_mode_ok | input | 1 | High when the current counting mode records overflow |
| gie | input | 1 | Global interrupt enable |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 status, 1 enable |
| reg_wr_data | input | 8 | Write data |
| reg_rd_sel | input | 1 | Read source: 0 status, 1 enable |
| reg_rd_data | output | 8 | Read data (combinational) |
| irq_ack | input | 3 | Per-source vector-taken acknowledge pulses |
| irq_req | output | 3 | Per-source interrupt requests |

## Verification
The collision that matters is a setting event meeting a clear on the same status bit in one cycle. The clear can come from a write-one or from an acknowledge. The bench drives the event pulse together with each kind of clear in a single cycle. It then reads the status register at the following falling edge and expects the bit to still be set. As a control, it applies the same clears without an event and expects the bit to clear. This separates a correct priority from one that simply ignores clears.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int NUM_SRC = 3;
  localparam int REG_W   = 8;
  localparam int IDX_OVF  = 0;
  localparam int IDX_CMPA = 1;
  localparam int IDX_CMPB = 2;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tic_status_bit.sv
module tic_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // Set dominates clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> flag_o);
  assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && flag_o) |=> flag_o);
endmodule

// File: rtl/tic_enable_reg.sv
module tic_enable_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (we_i) en_q <= d_i;
  end

  assign q_o = en_q;

  assert_enable_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (q_o == $past(d_i)));
  assert_enable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/tic_read_mux.sv
module tic_read_mux #(
  parameter int N = 3,
  parameter int W = 8
) (
  input  logic         sel_i,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] enable_i,
  output logic [W-1:0] data_o
);
  localparam int PAD = W - N;

  always_comb begin
    data_o = '0;
    if (sel_i == tic_pkg::SEL_ENABLE) data_o = {{PAD{1'b0}}, enable_i};
    else                              data_o = {{PAD{1'b0}}, status_i};
  end
endmodule

// File: rtl/tic_req_gate.sv
module tic_req_gate #(
  parameter int N = 3
) (
  input  logic         gie_i,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] enable_i,
  output logic [N-1:0] req_o
);
  for (genvar i = 0; i < N; i++) begin : g_req
    assign req_o[i] = gie_i & enable_i[i] & status_i[i];
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_ovf,
  input  logic       evt_cmp_a,
  input  logic       evt_cmp_b,
  input  logic       ovf_mode_ok,
  input  logic       gie,
  input  logic       reg_wr_en,
  input  logic       reg_wr_sel,
  input  logic [7:0] reg_wr_data,
  input  logic       reg_rd_sel,
  output logic [7:0] reg_rd_data,
  input  logic [2:0] irq_ack,
  output logic [2:0] irq_req
);
  import tic_pkg::*;

  logic [NUM_SRC-1:0] evt_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] enable_q;
  logic               wr_status;
  logic               wr_enable;
  logic               unused_wr_hi;

  assign unused_wr_hi = ^reg_wr_data[REG_W-1:NUM_SRC];

  assign wr_status = reg_wr_en && (reg_sel_e'(reg_wr_sel) == SEL_STATUS);
  assign wr_enable = reg_wr_en && (reg_sel_e'(reg_wr_sel) == SEL_ENABLE);

  always_comb begin
    evt_vec           = '0;
    evt_vec[IDX_OVF]  = evt_ovf & ovf_mode_ok;
    evt_vec[IDX_CMPA] = evt_cmp_a;
    evt_vec[IDX_CMPB] = evt_cmp_b;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign clr_vec[i] = (wr_status & reg_wr_data[i]) | irq_ack[i];

    tic_status_bit u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_vec[i]),
      .clr_i  (clr_vec[i]),
      .flag_o (status_q[i])
    );

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[i] && !evt_vec[i]) |=> !status_q[i]);
  end

  tic_enable_reg #(.N(NUM_SRC)) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (wr_enable),
    .d_i   (reg_wr_data[NUM_SRC-1:0]),
    .q_o   (enable_q)
  );

  tic_read_mux #(.N(NUM_SRC), .W(REG_W)) u_rd (
    .sel_i    (reg_rd_sel),
    .status_i (status_q),
    .enable_i (enable_q),
    .data_o   (reg_rd_data)
  );

  tic_req_gate #(.N(NUM_SRC)) u_gate (
    .gie_i    (gie),
    .status_i (status_q),
    .enable_i (enable_q),
    .req_o    (irq_req)
  );

  assert_ovf_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ovf && !ovf_mode_ok && !status_q[IDX_OVF]) |=> !status_q[IDX_OVF]);
  assert_no_req_without_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq_req == '0));
  assert_req_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~status_q) == '0);
  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[REG_W-1:NUM_SRC] == '0);
endmodule

// File: tb/tmr_irq_ctrl_bench.sv
module tmr_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_ovf = 1'b0, evt_cmp_a = 1'b0, evt_cmp_b = 1'b0;
  logic       ovf_mode_ok = 1'b1;
  logic       gie = 1'b0;
  logic       reg_wr_en = 1'b0, reg_wr_sel = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic       reg_rd_sel = 1'b0;
  logic [7:0] reg_rd_data;
  logic [2:0] irq_ack = 3'b000;
  logic [2:0] irq_req;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_irq_ctrl u_tmr_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .evt_ovf(evt_ovf), .evt_cmp_a(evt_cmp_a), .evt_cmp_b(evt_cmp_b),
    .ovf_mode_ok(ovf_mode_ok), .gie(gie),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  // ev: {cmp_b, cmp_a, ovf}; one clock with the given stimulus.
  task automatic step(input logic [2:0] ev, input logic [2:0] ak,
                      input logic wen, input logic wsel, input logic [7:0] wd);
    @(negedge clk);
    {evt_cmp_b, evt_cmp_a, evt_ovf} = ev;
    irq_ack = ak;
    reg_wr_en = wen; reg_wr_sel = wsel; reg_wr_data = wd;
    @(posedge clk);
    #1;
    {evt_cmp_b, evt_cmp_a, evt_ovf} = 3'b000;
    irq_ack = 3'b000;
    reg_wr_en = 1'b0; reg_wr_data = 8'h00;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    reg_rd_sel = sel;
    #1;
    v = reg_rd_data;
  endtask

  task automatic clear_all();
    step(3'b000, 3'b000, 1'b1, 1'b0, 8'hFF);
    step(3'b000, 3'b000, 1'b1, 1'b1, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v); chk("R1", "status after reset", v, 8'h00);
    rd(1'b1, v); chk("R1", "enable after reset", v, 8'h00);
    chk("R1", "irq after reset", {5'b0, irq_req}, 8'h00);
  endtask

  task automatic t_events();
    logic [7:0] v;
    step(3'b100, 3'b000, 1'b0, 1'b0, 8'h00);
    rd(1'b0, v); chk("R2", "cmp_b sets bit 2", v, 8'h04);
    step(3'b010, 3'b000, 1'b0, 1'b0, 8'h00);
    rd(1'b0, v); chk("R2", "cmp_a sets bit 1", v, 8'h06);
    step(3'b001, 3'b000, 1'b0, 1'b0, 8'h00);
    rd(1'b0, v); chk("R2", "ovf sets bit 0", v, 8'h07);
    step(3'b000, 3'b000, 1'b0, 1'b0, 8'h00);
    rd(1'b0, v); chk("R2", "bits sticky", v, 8'h07);
    clear_all();
  endtask

  task automatic t_ovf_gate();
    logic [7:0] v;
    ovf_mode_ok = 1'b0;
    step(3'b001, 3'b000, 1'b0, 1'b0, 8'h00);
    rd(1'b0, v); chk("R3", "ovf ignored when mode not ok", v, 8'h00);
    ovf_mode_ok = 1'b1;
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    step(3'b111, 3'b000, 1'b0, 1'b0, 8'h00);
    step(3'b000, 3'b000, 1'b1, 1'b0, 8'h02);
    rd(1'b0, v); chk("R4", "write one clears bit 1 only", v, 8'h05);
    step(3'b000, 3'b000, 1'b1, 1'b0, 8'h00);
    rd(1'b0, v); chk("R4", "write zero no effect", v, 8'h05);
    step(3'b000, 3'b000, 1'b1, 1'b0, 8'hF8);
    rd(1'b0, v); chk("R8", "reserved status write no effect", v, 8'h05);
    step(3'b000, 3'b100, 1'b0, 1'b0, 8'h00);
    rd(1'b0, v); chk("R5", "ack clears bit 2", v, 8'h01);
    step(3'b000, 3'b001, 1'b0, 1'b0, 8'h00);
    rd(1'b0, v); chk("R5", "ack clears bit 0", v, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] v;
    step(3'b010, 3'b000, 1'b0, 1'b0, 8'h00);
    step(3'b010, 3'b000, 1'b1, 1'b0, 8'h02);
    rd(1'b0, v); chk("R6", "event beats write-one clear", v, 8'h02);
    step(3'b010, 3'b010, 1'b0, 1'b0, 8'h00);
    rd(1'b0, v); chk("R6", "event beats ack clear", v, 8'h02);
    step(3'b000, 3'b000, 1'b1, 1'b0, 8'h02);
    rd(1'b0, v); chk("R6", "control clear without event", v, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    step(3'b000, 3'b000, 1'b1, 1'b1, 8'hFF);
    rd(1'b1, v); chk("R8", "enable reserved bits read zero", v, 8'h07);
    step(3'b111, 3'b000, 1'b0, 1'b0, 8'h00);
    gie = 1'b0;
    rd(1'b0, v); chk("R7", "no request with gie low", {5'b0, irq_req}, 8'h00);
    gie = 1'b1;
    rd(1'b0, v); chk("R7", "requests with all set", {5'b0, irq_req}, 8'h07);
    step(3'b000, 3'b000, 1'b1, 1'b1, 8'h05);
    rd(1'b1, v); chk("R9", "enable load", v, 8'h05);
    chk("R7", "masked source silent", {5'b0, irq_req}, 8'h05);
    clear_all();
  endtask

  task automatic t_pending();
    logic [7:0] v;
    gie = 1'b1;
    step(3'b100, 3'b000, 1'b0, 1'b0, 8'h00);
    rd(1'b0, v); chk("R9", "pending but disabled no request", {5'b0, irq_req}, 8'h00);
    step(3'b000, 3'b000, 1'b1, 1'b1, 8'h04);
    rd(1'b0, v); chk("R9", "request rises after enable write", {5'b0, irq_req}, 8'h04);
    step(3'b000, 3'b100, 1'b0, 1'b0, 8'h00);
    rd(1'b0, v); chk("R5", "ack drops request", {5'b0, irq_req}, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_events();
    t_ovf_gate();
    t_w1c();
    t_race();
    t_mask();
    t_pending();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule